// File: doc/BRIEF.md
# Ternary Word Shifter with Condition Trits

This block moves the trits of a nine-trit word by one to nine places. It supports three shift kinds: toward the high end, toward the low end with zero fill, and toward the low end with sign fill. Along with the shifted word it produces three condition trits: a sign, an overflow and a carry. It is the shift unit of a small ternary datapath. The caller provides the shift kind, a two-trit count and the operand, and reads back the result and the flags. Each trit is carried on a pair of wires.

Words use three's-complement signed weighting. A word whose unsigned weight is above 9841 counts as negative. A left shift multiplies the value by a power of three. The two right shifts divide by a power of three. The unsigned right shift truncates, and the signed right shift rounds toward minus infinity. The overflow trit reports a left shift whose exact signed product no longer fits in the word. For a right shift, it reports that a nonzero trit was dropped. The carry trit always holds the last trit that left the word.

The datapath is combinational. By default a register stage follows it, which adds one cycle of latency. Any wire pair carrying the unused code 11 on any input causes the error output to be raised.

Top module: `ternary_shifter`

## Requirements
- R1: A count of value zero (both count trits 0) shifts by nine places. Any other count shifts by its value. The count's high trit sits on bits [3:2] and weighs 3, and its low trit sits on bits [1:0].
- R2: Shift kind 0 (left) gives (u × 3^n) mod 19683, with zeros entering at trit 0. Here u is the unsigned weight of the operand and trit i sits on bits [2i+1:2i].
- R3: On a left shift, the overflow trit is 1 exactly when the operand's signed value times 3^n lies outside −9841..+9841. Otherwise it is 0.
- R4: The carry trit equals the last trit shifted out. For a left shift this is operand trit 9−n. For either right shift it is operand trit n−1.
- R5: Shift kind 1 (right, unsigned) gives floor(u / 3^n), with zeros entering at the top. Its sign trit is never 2.
- R6: Shift kind 2 (right, signed) fills with trit 2 when the operand is negative and with 0 otherwise. The result equals floor(signed value / 3^n) in three's complement.
- R7: On either right shift, the overflow trit is 1 exactly when any trit shifted out was nonzero.
- R8: The sign trit is 0 for a zero result, 1 for a result weight of 1..9841, and 2 for a result weight of 9842..19682.
- R9: Trit codes are 00=0, 01=1 and 10=2. The code 11 anywhere in the operand, the count or the shift kind raises err_o. In that case the result and all three flags are 0, and every result trit is otherwise a legal code.
- R10: With the register stage enabled, the outputs change one clock after the inputs. A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_type_i | input | 2 | Shift kind trit: 0 left, 1 right unsigned, 2 right signed |
| count_i | input | 4 | Two-trit shift count, with code 0 meaning nine |
| operand_i | input | 18 | Nine-trit operand, two wires per trit |
| result_o | output | 18 | Shifted word |
| sign_o | output | 2 | Sign condition trit |
| ovf_o | output | 2 | Overflow condition trit |
| carry_o | output | 2 | Last trit shifted out |
| err_o | output | 1 | An input carried an illegal trit code |

## Verification
The sweep covers every shift kind with every count against several thousand operands, and the bench computes each answer with integer arithmetic. It aims at five corner cases:
- Count code zero. A design that read this code as "no shift" would return the operand unchanged.
- Operands such as 4 shifted left by eight. Here the sign survives but precision is lost, so a design that compared signs only would leave overflow clear.
- Negative operands on the signed right shift. With zero fill they would become large positive values, and a design that truncated toward zero would be off by one.
- The weights 9841 and 9842. These straddle the sign boundary and catch an off-by-one in the sign trit.
- Illegal codes on each input. These must be caught with the result held at zero.

// File: rtl/ternshift_pkg.sv
`timescale 1ns/1ps
// Shared types and constant helpers for the ternary shifter.
// Assumes trits are carried as 2-bit codes 00/01/10, with 11 illegal.
package ternshift_pkg;

    typedef enum logic [1:0] {
        SHK_LEFT    = 2'd0,
        SHK_RIGHT_U = 2'd1,
        SHK_RIGHT_S = 2'd2,
        SHK_BAD     = 2'd3
    } shift_kind_e;

    localparam logic [1:0] TRIT_0 = 2'b00;
    localparam logic [1:0] TRIT_1 = 2'b01;
    localparam logic [1:0] TRIT_2 = 2'b10;

    // Integer power of three, for elaboration-time constants.
    function automatic int pow3(input int k);
        int p;
        p = 1;
        for (int i = 0; i < k; i++) p = p * 3;
        return p;
    endfunction

    // Largest positive signed magnitude of a k-trit three's-complement word.
    function automatic int half_range(input int k);
        return (pow3(k) - 1) / 2;
    endfunction

endpackage

// File: rtl/trit_word_value.sv
`timescale 1ns/1ps
// Converts a packed trit word into its unsigned binary weight.
// It also reports whether every trit carries a legal code.
// Assumes VAL_W is wide enough to hold 3^TRITS - 1.
module trit_word_value #(
    parameter int TRITS = 9,
    parameter int VAL_W = 15
) (
    input  logic [2*TRITS-1:0] word_i,
    output logic [VAL_W-1:0]   value_o,
    output logic               legal_o
);

    // Horner evaluation from the top trit down, plus the illegal-code scan.
    always_comb begin
        value_o = '0;
        legal_o = 1'b1;
        for (int i = TRITS - 1; i >= 0; i--) begin
            value_o = VAL_W'(value_o * VAL_W'(3)) + VAL_W'(word_i[2*i +: 2]);
            if (word_i[2*i +: 2] == 2'b11) legal_o = 1'b0;
        end
    end

endmodule

// File: rtl/trit_shift_core.sv
`timescale 1ns/1ps
// Barrel shifter over trit codes. Every shift amount from 1 to TRITS is
// built as a constant shift, and amt_i picks one of them.
// Assumes amt_i is within 1..TRITS. Outside that range the output is zero.
module trit_shift_core
    import ternshift_pkg::*;
#(
    parameter int TRITS = 9,
    parameter int AMT_W = 4
) (
    input  logic [2*TRITS-1:0] word_i,
    input  shift_kind_e        kind_i,
    input  logic [AMT_W-1:0]   amt_i,
    input  logic               negative_i,
    output logic [2*TRITS-1:0] word_o,
    output logic [1:0]         last_out_o,
    output logic               lost_o
);

    localparam int W = 2 * TRITS;
    localparam logic [W-1:0] ONES = '1;
    localparam logic [W-1:0] TWOS = {TRITS{TRIT_2}};

    logic [W-1:0] shl      [1:TRITS];
    logic [W-1:0] shr      [1:TRITS];
    logic [W-1:0] top_fill [1:TRITS];
    logic         lost_k   [1:TRITS];
    logic [1:0]   out_l    [1:TRITS];
    logic [1:0]   out_r    [1:TRITS];

    // One set of constant-distance candidates per shift amount.
    for (genvar k = 1; k <= TRITS; k++) begin : g_amt
        assign shl[k]      = word_i << (2 * k);
        assign shr[k]      = word_i >> (2 * k);
        assign top_fill[k] = TWOS & ~(ONES >> (2 * k));
        assign lost_k[k]   = |(word_i & ~(ONES << (2 * k)));
        assign out_l[k]    = word_i[2*(TRITS-k) +: 2];
        assign out_r[k]    = word_i[2*(k-1) +: 2];
    end

    // Pick the candidate for the requested amount and shift kind.
    always_comb begin
        word_o     = '0;
        last_out_o = TRIT_0;
        lost_o     = 1'b0;
        for (int k = 1; k <= TRITS; k++) begin
            if (amt_i == AMT_W'(k)) begin
                case (kind_i)
                    SHK_RIGHT_U: begin
                        word_o     = shr[k];
                        last_out_o = out_r[k];
                        lost_o     = lost_k[k];
                    end
                    SHK_RIGHT_S: begin
                        word_o     = shr[k] | (negative_i ? top_fill[k] : '0);
                        last_out_o = out_r[k];
                        lost_o     = lost_k[k];
                    end
                    default: begin
                        word_o     = shl[k];
                        last_out_o = out_l[k];
                        lost_o     = 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/trit_flag_gen.sv
`timescale 1ns/1ps
// Derives the sign, overflow and carry condition trits of a shift.
// A left shift overflows when |operand| exceeds (3^(TRITS-n)-1)/2, because
// the exact product is then outside the signed range.
// Assumes op_mag_i is the operand's signed magnitude.
module trit_flag_gen
    import ternshift_pkg::*;
#(
    parameter int TRITS = 9,
    parameter int VAL_W = 15,
    parameter int AMT_W = 4
) (
    input  shift_kind_e      kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [VAL_W-1:0] op_mag_i,
    input  logic [VAL_W-1:0] res_value_i,
    input  logic             lost_i,
    input  logic [1:0]       last_out_i,
    output logic [1:0]       sign_o,
    output logic [1:0]       ovf_o,
    output logic [1:0]       carry_o
);

    localparam logic [VAL_W-1:0] HALF = VAL_W'(half_range(TRITS));

    logic [VAL_W-1:0] limit;

    // Largest magnitude that still fits after a left shift by amt_i places.
    always_comb begin
        limit = '0;
        for (int k = 1; k <= TRITS; k++) begin
            if (amt_i == AMT_W'(k)) limit = VAL_W'(half_range(TRITS - k));
        end
    end

    // Sign trit from the weight of the result.
    always_comb begin
        if (res_value_i == '0)       sign_o = TRIT_0;
        else if (res_value_i <= HALF) sign_o = TRIT_1;
        else                          sign_o = TRIT_2;
    end

    // Overflow: lost precision on a left shift, a dropped nonzero trit on a right shift.
    always_comb begin
        if (kind_i == SHK_LEFT) ovf_o = (op_mag_i > limit) ? TRIT_1 : TRIT_0;
        else                    ovf_o = lost_i ? TRIT_1 : TRIT_0;
    end

    assign carry_o = last_out_i;

endmodule

// File: rtl/ternary_shifter.sv
`timescale 1ns/1ps
// Ternary shifter top. It decodes the count and operand, shifts, builds the
// condition trits and, when REG_OUT is set, registers all outputs.
// Assumes a synchronous active-low reset and a count range that does not
// exceed TRITS.
module ternary_shifter
    import ternshift_pkg::*;
#(
    parameter int TRITS     = 9,
    parameter int CNT_TRITS = 2,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           shift_type_i,
    input  logic [2*CNT_TRITS-1:0] count_i,
    input  logic [2*TRITS-1:0]   operand_i,
    output logic [2*TRITS-1:0]   result_o,
    output logic [1:0]           sign_o,
    output logic [1:0]           ovf_o,
    output logic [1:0]           carry_o,
    output logic                 err_o
);

    localparam int W         = 2 * TRITS;
    localparam int VAL_W     = $clog2(pow3(TRITS));
    localparam int CNT_VAL_W = $clog2(pow3(CNT_TRITS));
    localparam int AMT_W     = $clog2(TRITS + 1);
    localparam logic [VAL_W-1:0] HALF    = VAL_W'(half_range(TRITS));
    localparam logic [VAL_W-1:0] MODULUS = VAL_W'(pow3(TRITS));

    shift_kind_e          kind;
    logic [CNT_VAL_W-1:0] cnt_val;
    logic                 cnt_legal;
    logic [AMT_W-1:0]     amt;
    logic [VAL_W-1:0]     op_val, op_mag, res_val;
    logic                 op_legal, op_neg, res_legal;
    logic [W-1:0]         sh_word;
    logic [1:0]           sh_last, s_raw, v_raw, c_raw;
    logic                 sh_lost;
    logic                 err_n;
    logic [W-1:0]         res_n;
    logic [1:0]           sign_n, ovf_n, carry_n;

    assign kind = shift_kind_e'(shift_type_i);

    trit_word_value #(.TRITS(CNT_TRITS), .VAL_W(CNT_VAL_W)) u_cnt_dec (
        .word_i(count_i), .value_o(cnt_val), .legal_o(cnt_legal)
    );

    // A count of zero stands for a full-width shift.
    assign amt = (cnt_val == '0) ? AMT_W'(TRITS) : AMT_W'(cnt_val);

    trit_word_value #(.TRITS(TRITS), .VAL_W(VAL_W)) u_op_dec (
        .word_i(operand_i), .value_o(op_val), .legal_o(op_legal)
    );

    // Signed view of the operand: negative above the half range.
    assign op_neg = (op_val > HALF);
    assign op_mag = op_neg ? (MODULUS - op_val) : op_val;

    trit_shift_core #(.TRITS(TRITS), .AMT_W(AMT_W)) u_core (
        .word_i(operand_i), .kind_i(kind), .amt_i(amt), .negative_i(op_neg),
        .word_o(sh_word), .last_out_o(sh_last), .lost_o(sh_lost)
    );

    trit_word_value #(.TRITS(TRITS), .VAL_W(VAL_W)) u_res_dec (
        .word_i(sh_word), .value_o(res_val), .legal_o(res_legal)
    );

    trit_flag_gen #(.TRITS(TRITS), .VAL_W(VAL_W), .AMT_W(AMT_W)) u_flags (
        .kind_i(kind), .amt_i(amt), .op_mag_i(op_mag), .res_value_i(res_val),
        .lost_i(sh_lost), .last_out_i(sh_last),
        .sign_o(s_raw), .ovf_o(v_raw), .carry_o(c_raw)
    );

    // Any illegal input code forces a quiet, all-zero answer.
    assign err_n   = !op_legal || !cnt_legal || (kind == SHK_BAD);
    assign res_n   = err_n ? '0 : sh_word;
    assign sign_n  = err_n ? TRIT_0 : s_raw;
    assign ovf_n   = err_n ? TRIT_0 : v_raw;
    assign carry_n = err_n ? TRIT_0 : c_raw;

    if (REG_OUT) begin : g_reg
        // Output register stage with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result_o <= '0;
                sign_o   <= TRIT_0;
                ovf_o    <= TRIT_0;
                carry_o  <= TRIT_0;
                err_o    <= 1'b0;
            end else begin
                result_o <= res_n;
                sign_o   <= sign_n;
                ovf_o    <= ovf_n;
                carry_o  <= carry_n;
                err_o    <= err_n;
            end
        end

        // R10: outputs follow the datapath one cycle later.
        p_reg_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (result_o == $past(res_n)) && (err_o == $past(err_n)));
    end else begin : g_comb
        assign result_o = res_n;
        assign sign_o   = sign_n;
        assign ovf_o    = ovf_n;
        assign carry_o  = carry_n;
        assign err_o    = err_n;
    end

    // R5: an unsigned right shift never yields a negative sign and fills with zero.
    p_unsigned_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n && kind == SHK_RIGHT_U) |-> (sign_n != TRIT_2) && (res_n[W-1 -: 2] == TRIT_0));

    // R6: a negative operand on a signed right shift gets trit 2 at the top.
    p_signed_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n && kind == SHK_RIGHT_S && op_neg) |-> (res_n[W-1 -: 2] == TRIT_2));

    // R3: shifting a zero operand left can never overflow.
    p_zero_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n && kind == SHK_LEFT && op_val == '0) |-> (ovf_n == TRIT_0) && (sign_n == TRIT_0));

    // R9: an error yields an all-zero answer, and otherwise the result trits are legal.
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_n |-> (res_n == '0) && (sign_n == TRIT_0) && (ovf_n == TRIT_0) && (carry_n == TRIT_0));
    p_result_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> res_legal);

endmodule

// File: tb/ternary_shifter_bench.sv
`timescale 1ns/1ps
// Sweeps all shift kinds and counts over a strided operand set, with
// expected values computed by integer arithmetic.
module ternary_shifter_bench;

    localparam int T = 9;
    localparam int M = 19683;
    localparam int H = 9841;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  shift_type_i = 2'd0;
    logic [3:0]  count_i = 4'd0;
    logic [17:0] operand_i = '0;
    logic [17:0] result_o;
    logic [1:0]  sign_o, ovf_o, carry_o;
    logic        err_o;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ternary_shifter #(.TRITS(T), .CNT_TRITS(2), .REG_OUT(1'b1)) u_ternary_shifter (
        .clk(clk), .rst_n(rst_n), .shift_type_i(shift_type_i), .count_i(count_i),
        .operand_i(operand_i), .result_o(result_o), .sign_o(sign_o),
        .ovf_o(ovf_o), .carry_o(carry_o), .err_o(err_o)
    );

    function automatic int p3(input int k);
        int p;
        p = 1;
        for (int i = 0; i < k; i++) p = p * 3;
        return p;
    endfunction

    function automatic logic [17:0] enc(input int u);
        logic [17:0] e;
        int x;
        x = u;
        for (int i = 0; i < T; i++) begin
            e[2*i +: 2] = 2'(x % 3);
            x = x / 3;
        end
        return e;
    endfunction

    function automatic int dec(input logic [17:0] w);
        int v;
        v = 0;
        for (int i = T - 1; i >= 0; i--) v = v * 3 + int'(w[2*i +: 2]);
        return v;
    endfunction

    function automatic logic [3:0] ccode(input int n);
        int c;
        c = n % 9;
        return {2'(c / 3), 2'(c % 3)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp, input string what);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input int kind, input int n, input int u);
        int pw, r, c, v, s, sv, q, p;
        string rt, vt;
        pw = p3(n);
        sv = (u > H) ? u - M : u;
        if (kind == 0) begin
            r  = (u * pw) % M;
            c  = (u / p3(T - n)) % 3;
            p  = sv * pw;
            v  = (p > H || p < -H) ? 1 : 0;
            rt = "R2";
            vt = "R3";
        end else begin
            c  = (u / (pw / 3)) % 3;
            v  = ((u % pw) != 0) ? 1 : 0;
            vt = "R7";
            if (kind == 1) begin
                r  = u / pw;
                rt = "R5";
            end else begin
                if (sv >= 0) q = sv / pw;
                else         q = -((-sv + pw - 1) / pw);
                r  = (q < 0) ? q + M : q;
                rt = "R6";
            end
        end
        if (n == T) rt = "R1";
        s = (r == 0) ? 0 : ((r <= H) ? 1 : 2);
        @(negedge clk);
        shift_type_i = 2'(kind);
        count_i      = ccode(n);
        operand_i    = enc(u);
        @(posedge clk);
        #1;
        chk(rt,   dec(result_o), r, $sformatf("result kind=%0d n=%0d u=%0d", kind, n, u));
        chk(vt,   int'(ovf_o),   v, $sformatf("ovf kind=%0d n=%0d u=%0d", kind, n, u));
        chk("R4", int'(carry_o), c, $sformatf("carry kind=%0d n=%0d u=%0d", kind, n, u));
        chk("R8", int'(sign_o),  s, $sformatf("sign kind=%0d n=%0d u=%0d", kind, n, u));
        chk("R9", int'(err_o),   0, "err on legal input");
    endtask

    task automatic run_bad(input logic [1:0] ty, input logic [3:0] cn, input logic [17:0] op, input string what);
        @(negedge clk);
        shift_type_i = ty;
        count_i      = cn;
        operand_i    = op;
        @(posedge clk);
        #1;
        chk("R9", int'(err_o), 1, {what, " err"});
        chk("R9", int'(result_o == '0 && sign_o == 2'b00 && ovf_o == 2'b00 && carry_o == 2'b00),
            1, {what, " quiet outputs"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            ntests++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        int edge_ops[14] = '{0, 1, 2, 4, 5, 3280, 6561, 9840, 9841, 9842, 9843, 13122, 19681, 19682};
        shift_type_i = 2'd0;
        count_i      = 4'b0001;
        operand_i    = enc(19682);
        repeat (3) @(posedge clk);
        #1;
        // R10: reset clears everything.
        chk("R10", dec(result_o), 0, "result in reset");
        chk("R10", int'({sign_o, ovf_o, carry_o, err_o}), 0, "flags in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Flag examples for operand 4 shifted left by eight: s=1, v=1, c=1.
        run_vec(0, 8, 4);
        // R10: a new input is not visible before the next edge.
        @(negedge clk);
        operand_i = enc(2);
        #1;
        chk("R10", dec(result_o), 6561, "result before edge");
        @(posedge clk);
        #1;
        chk("R10", dec(result_o), 13122, "result after edge");

        for (int kind = 0; kind < 3; kind++)
            for (int n = 1; n <= T; n++) begin
                foreach (edge_ops[i]) run_vec(kind, n, edge_ops[i]);
                for (int u = 3; u < M; u += 7) run_vec(kind, n, u);
            end

        // R9: illegal codes on each input.
        for (int k = 0; k < T; k++) begin
            logic [17:0] bad;
            bad = enc(1234);
            bad[2*k +: 2] = 2'b11;
            run_bad(2'd0, 4'b0001, bad, $sformatf("operand trit %0d", k));
        end
        run_bad(2'd3, 4'b0001, enc(100), "shift kind");
        run_bad(2'd1, 4'b0011, enc(100), "count low trit");
        run_bad(2'd2, 4'b1100, enc(100), "count high trit");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule